// File: doc/BRIEF.md
# CRC-32C Streaming Digest Engine

This block computes a 32-bit cyclic check with the Castagnoli generator over a data unit that arrives one byte per clock. A one-cycle start pulse opens a unit. Bytes are accepted while a valid strobe is high, and a last flag marks the final byte. When the unit length is not a multiple of the alignment (four bytes by default), the engine feeds the required zero bytes into the check itself, one per cycle. It then raises a single-cycle done strobe, and the finished digest appears on its output.

Two mode inputs are captured on the start pulse. A digest-enable input selects between producing a digest and the "none" setting, in which no digest is reported or compared. A check-enable input makes the engine compare its result against a received 32-bit value and raise a mismatch flag with done. Header and payload regions are separate units: each start clears the running state. A start that arrives while a unit is in progress abandons that unit.

Top module: `crc32c_digest_engine`

## Requirements
- R1: After reset, done_o, digest_valid_o and mismatch_o are 0 and digest_o reads 0.
- R2: The check uses the reversed generator 0x82F63B78 (full form 0x11EDC6F41), a preset of 0xFFFFFFFF, LSB-first byte processing and a final inversion. With ALIGN_BYTES=1, the ASCII bytes "123456789" give digest 0xE3069283.
- R3: After the last byte, (ALIGN_BYTES - len mod ALIGN_BYTES) mod ALIGN_BYTES zero bytes are folded into the check, one per cycle. done_o rises exactly that many cycles plus one after the clock edge that takes the last byte. For example, 32 zero bytes give 0x8A9136AA and 32 bytes of 0xFF give 0x62A8AB43.
- R4: done_o is high for exactly one cycle. digest_o stays unchanged after done until the next start.
- R5: When digest_en_i is 0 at start, done_o still pulses at the normal time, but digest_o reads 0, digest_valid_o stays 0 and mismatch_o stays 0. When digest_en_i is 1, digest_valid_o is high together with done_o.
- R6: When check_en_i and digest_en_i are 1 at start, mismatch_o is high with done_o exactly when digest_o differs from expect_i. Otherwise mismatch_o is 0.
- R7: A start pulse in any state restarts the unit from the preset. A valid byte in the same cycle as start is the first byte of the new unit.
- R8: Cycles with byte_valid_i low inside a unit do not change the result. Bytes presented with no unit open (no start) are ignored: no done, and digest_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a new unit; presets the check and captures the modes |
| byte_valid_i | input | 1 | byte_i carries a data byte this cycle |
| byte_i | input | 8 | Data byte |
| last_i | input | 1 | With byte_valid_i: this is the final byte of the unit |
| digest_en_i | input | 1 | 1 = produce a digest, 0 = none setting (captured at start) |
| check_en_i | input | 1 | 1 = compare against expect_i (captured at start) |
| expect_i | input | 32 | Received digest to compare against at done |
| done_o | output | 1 | One-cycle strobe when the unit, including padding, is finished |
| digest_valid_o | output | 1 | done_o together with an enabled digest |
| digest_o | output | 32 | Final digest (0 in the none setting) |
| mismatch_o | output | 1 | Check-mode result differs from expect_i |

## Verification
The engine is driven with several byte patterns: all zeros, all ones, an incrementing odd-stride sequence and ASCII digits. Known constants for all-zero and all-ones data pin down the preset and the final inversion independently of bit order, and the digit string pins down reflection and the polynomial. Lengths 1 to 13 cover every residue modulo four, which separates correct padding count and done timing from off-by-one padding. Gapped streams, idle bytes, aborts during data and during padding, and the none and check modes each compare against the bench's bitwise reference.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;
   localparam int unsigned CRC_W      = 32;
   localparam logic [31:0] POLY_REFL  = 32'h82F63B78;
   localparam logic [31:0] PRESET     = 32'hFFFF_FFFF;
   localparam logic [31:0] FINAL_XOR  = 32'hFFFF_FFFF;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_PAD  = 2'd2,
      ST_FIN  = 2'd3
   } unit_st_t;
endpackage

// File: rtl/crc32c_byte_step.sv
module crc32c_byte_step #(
   parameter int unsigned          W      = 32,
   parameter int unsigned          BYTE_W = 8,
   parameter logic [W-1:0]         POLY   = 32'h82F63B78
) (
   input  logic [W-1:0]      crc_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic [W-1:0]      crc_o
);
   if (BYTE_W > W) begin : g_bad_width
      $error("crc32c_byte_step: BYTE_W must not exceed W");
   end

   logic [W-1:0] stage [BYTE_W+1];

   assign stage[0] = crc_i ^ {{(W-BYTE_W){1'b0}}, data_i};

   for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
      assign stage[k+1] = stage[k][0] ? ((stage[k] >> 1) ^ POLY)
                                      :  (stage[k] >> 1);
   end

   assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/crc32c_pad_ctrl.sv
module crc32c_pad_ctrl
   import crc32c_pkg::*;
#(
   parameter int unsigned ALIGN_BYTES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic valid_i,
   input  logic last_i,
   output logic step_en_o,
   output logic step_pad_o,
   output logic done_o
);
   if (ALIGN_BYTES == 0 || (ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0) begin : g_bad_align
      $error("crc32c_pad_ctrl: ALIGN_BYTES must be a power of two");
   end

   unit_st_t st_q, st_d;
   logic     take;

   assign take       = valid_i && (start_i || st_q == ST_ACT);
   assign step_pad_o = (st_q == ST_PAD) && !start_i;
   assign step_en_o  = take || step_pad_o;
   assign done_o     = (st_q == ST_FIN);

   if (ALIGN_BYTES == 1) begin : g_noalign
      always_comb begin
         st_d = st_q;
         if (start_i) begin
            st_d = (take && last_i) ? ST_FIN : ST_ACT;
         end else begin
            case (st_q)
               ST_ACT:  if (take && last_i) st_d = ST_FIN;
               ST_FIN:  st_d = ST_IDLE;
               default: st_d = st_q;
            endcase
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= ST_IDLE;
         else        st_q <= st_d;
      end
   end else begin : g_align
      localparam int unsigned CNT_W = $clog2(ALIGN_BYTES);
      localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

      logic [CNT_W-1:0] cnt_q, cnt_d, pad_q, pad_d;
      logic [CNT_W-1:0] cnt_base, cnt_next, pad_need;

      always_comb begin
         cnt_base = start_i ? '0 : cnt_q;
         cnt_next = cnt_base + ONE;
         pad_need = '0 - cnt_next;

         st_d  = st_q;
         cnt_d = cnt_q;
         pad_d = pad_q;

         if (take)              cnt_d = cnt_next;
         else if (start_i)      cnt_d = '0;
         if (start_i)           st_d  = ST_ACT;

         if (take && last_i) begin
            pad_d = pad_need;
            st_d  = (pad_need == '0) ? ST_FIN : ST_PAD;
         end else if (!start_i) begin
            case (st_q)
               ST_PAD: begin
                  pad_d = pad_q - ONE;
                  if (pad_q == ONE) st_d = ST_FIN;
               end
               ST_FIN:  st_d = ST_IDLE;
               default: st_d = st_q;
            endcase
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            pad_q <= '0;
         end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            pad_q <= pad_d;
         end
      end

      // R3: the final pad cycle hands over to the finish cycle
      p_pad_to_fin_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q == ST_PAD && pad_q == ONE && !start_i) |=> (st_q == ST_FIN));

      // R3: padding is only entered with work left to do
      p_pad_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q == ST_PAD) |-> (pad_q != '0));
   end

   // R8: no unit open and no start means no update
   p_idle_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !start_i) |-> !step_en_o);

   // R3: a last byte always leaves the data phase
   p_last_leaves_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last_i) |=> (st_q != ST_ACT));
endmodule

// File: rtl/crc32c_digest_engine.sv
module crc32c_digest_engine
   import crc32c_pkg::*;
#(
   parameter int unsigned ALIGN_BYTES = 4,
   parameter int unsigned BYTE_W      = 8,
   parameter logic [31:0] POLY        = POLY_REFL,
   parameter logic [31:0] INIT        = PRESET,
   parameter logic [31:0] XOR_OUT     = FINAL_XOR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              byte_valid_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              last_i,
   input  logic              digest_en_i,
   input  logic              check_en_i,
   input  logic [CRC_W-1:0]  expect_i,
   output logic              done_o,
   output logic              digest_valid_o,
   output logic [CRC_W-1:0]  digest_o,
   output logic              mismatch_o
);
   if (BYTE_W != 8) begin : g_bad_byte
      $error("crc32c_digest_engine: byte-serial engine needs BYTE_W == 8");
   end

   logic              step_en, step_pad, fin;
   logic              dig_en_q, chk_en_q;
   logic [CRC_W-1:0]  crc_q, crc_d, crc_src, crc_step, digest_w;
   logic [BYTE_W-1:0] data_src;

   crc32c_pad_ctrl #(.ALIGN_BYTES(ALIGN_BYTES)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .valid_i    (byte_valid_i),
      .last_i     (last_i),
      .step_en_o  (step_en),
      .step_pad_o (step_pad),
      .done_o     (fin)
   );

   assign crc_src  = start_i  ? INIT : crc_q;
   assign data_src = step_pad ? '0   : byte_i;

   crc32c_byte_step #(.W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY)) u_step (
      .crc_i  (crc_src),
      .data_i (data_src),
      .crc_o  (crc_step)
   );

   assign crc_d = step_en ? crc_step : crc_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q    <= INIT;
         dig_en_q <= 1'b0;
         chk_en_q <= 1'b0;
      end else begin
         crc_q <= crc_d;
         if (start_i) begin
            dig_en_q <= digest_en_i;
            chk_en_q <= check_en_i;
         end
      end
   end

   assign digest_w       = crc_q ^ XOR_OUT;
   assign done_o         = fin;
   assign digest_valid_o = fin && dig_en_q;
   assign digest_o       = dig_en_q ? digest_w : '0;
   assign mismatch_o     = fin && dig_en_q && chk_en_q && (digest_w != expect_i);

   // R4: done is a single-cycle strobe unless a new unit finishes at once
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);

   // R7: a start without a byte leaves the register at the preset
   p_start_presets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !byte_valid_i) |=> (crc_q == INIT));

   // R5: mode bits change only on a start
   p_modes_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(dig_en_q) && $stable(chk_en_q)));

   // R4: the digest holds after done until the next start
   p_digest_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> $stable(digest_o));
endmodule

// File: tb/sim_crc32c_digest_engine.sv
module sim_crc32c_digest_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, byte_valid_i = 1'b0, last_i = 1'b0;
   logic [7:0]  byte_i = '0;
   logic        digest_en_i = 1'b1, check_en_i = 1'b0;
   logic [31:0] expect_i = '0;
   logic        done0, dv0, mm0, done1, dv1, mm1;
   logic [31:0] dig0, dig1;

   int checks = 0;
   int fails  = 0;
   logic [31:0] u1_dig;

   always #10 clk = ~clk;

   crc32c_digest_engine #(.ALIGN_BYTES(4)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
      .byte_i(byte_i), .last_i(last_i), .digest_en_i(digest_en_i),
      .check_en_i(check_en_i), .expect_i(expect_i), .done_o(done0),
      .digest_valid_o(dv0), .digest_o(dig0), .mismatch_o(mm0));

   crc32c_digest_engine #(.ALIGN_BYTES(1)) u1 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
      .byte_i(byte_i), .last_i(last_i), .digest_en_i(digest_en_i),
      .check_en_i(check_en_i), .expect_i(expect_i), .done_o(done1),
      .digest_valid_o(dv1), .digest_o(dig1), .mismatch_o(mm1));

   typedef struct packed {
      logic [7:0] len;
      logic [1:0] kind;
      logic       gap;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{8'd1,  2'd3, 1'b0}, '{8'd2,  2'd3, 1'b0}, '{8'd3,  2'd2, 1'b0},
      '{8'd4,  2'd3, 1'b0}, '{8'd5,  2'd1, 1'b0}, '{8'd7,  2'd3, 1'b1},
      '{8'd8,  2'd2, 1'b0}, '{8'd13, 2'd3, 1'b1}};

   function automatic logic [7:0] pat(input int kind, input int i);
      case (kind)
         0:       return 8'h00;
         1:       return 8'hFF;
         2:       return 8'h31 + 8'(i % 9);
         default: return 8'(i * 37 + 5);
      endcase
   endfunction

   function automatic logic [31:0] ref_crc(input int kind, input int len, input int align);
      logic [31:0] c = 32'hFFFF_FFFF;
      int total = ((len + align - 1) / align) * align;
      for (int i = 0; i < total; i++) begin
         c ^= {24'h0, (i < len) ? pat(kind, i) : 8'h00};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input int kind, input int len, input bit gap);
      for (int i = 0; i < len; i++) begin
         if (gap && i > 0) begin
            @(negedge clk);
            start_i = 1'b0; byte_valid_i = 1'b0; last_i = 1'b0; byte_i = 8'hA5;
         end
         @(negedge clk);
         start_i = (i == 0); byte_valid_i = 1'b1;
         byte_i = pat(kind, i); last_i = (i == len - 1);
      end
      @(negedge clk);
      start_i = 1'b0; byte_valid_i = 1'b0; last_i = 1'b0;
   endtask

   task automatic run_unit(input int kind, input int len, input bit gap,
                           input bit den, input bit cen, input logic [31:0] exp_v,
                           input string tag);
      int p = (4 - len % 4) % 4;
      logic [31:0] want = ref_crc(kind, len, 4);
      digest_en_i = den; check_en_i = cen; expect_i = exp_v;
      send(kind, len, gap);
      chk(done1 == 1'b1, {tag, " R3 u1 done"}, 32'(done1), 32'd1);
      u1_dig = dig1;
      if (den) chk(dig1 == ref_crc(kind, len, 1), {tag, " R2 u1 digest"}, dig1, ref_crc(kind, len, 1));
      for (int j = 0; j < p; j++) begin
         chk(done0 == 1'b0, {tag, " R3 done too early"}, 32'(done0), 32'd0);
         @(negedge clk);
      end
      chk(done0 == 1'b1, {tag, " R3 done timing"}, 32'(done0), 32'd1);
      if (den) begin
         chk(dig0 == want, {tag, " R3 padded digest"}, dig0, want);
         chk(dv0 == 1'b1, {tag, " R5 digest valid"}, 32'(dv0), 32'd1);
      end else begin
         chk(dig0 == 32'h0 && dv0 == 1'b0, {tag, " R5 none mode quiet"}, dig0, 32'h0);
      end
      chk(mm0 == (den && cen && exp_v != want), {tag, " R6 mismatch"},
          32'(mm0), 32'(den && cen && exp_v != want));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      chk(done0 == 0 && dv0 == 0 && mm0 == 0 && dig0 == 0, "R1 reset outputs",
          {done0, dv0, mm0, dig0[28:0]}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done0 == 0 && dig0 == 0, "R1 after release", dig0, 32'h0);

      // table walk: R2 R3 R8 across lengths and patterns
      for (int v = 0; v < NV; v++) begin
         run_unit(int'(VECS[v].kind), int'(VECS[v].len), VECS[v].gap, 1'b1, 1'b0, 32'h0, "table");
      end

      // R2: digit string on the unpadded instance
      run_unit(2, 9, 1'b0, 1'b1, 1'b0, 32'h0, "digits");
      chk(u1_dig == 32'hE3069283, "R2 check value", u1_dig, 32'hE3069283);

      // R3: aligned known constants
      run_unit(0, 32, 1'b0, 1'b1, 1'b0, 32'h0, "zeros");
      chk(dig0 == 32'h8A9136AA, "R3 zeros constant", dig0, 32'h8A9136AA);
      run_unit(1, 32, 1'b0, 1'b1, 1'b0, 32'h0, "ones");
      chk(dig0 == 32'h62A8AB43, "R3 ones constant", dig0, 32'h62A8AB43);

      // R4: single pulse and held digest
      held = dig0;
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         chk(done0 == 0, "R4 done single cycle", 32'(done0), 32'd0);
         chk(dig0 == held, "R4 digest held", dig0, held);
      end

      // R8: bytes with no unit open are ignored
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         byte_valid_i = 1'b1; last_i = 1'b1; byte_i = 8'h5A;
      end
      @(negedge clk);
      byte_valid_i = 1'b0; last_i = 1'b0;
      for (int j = 0; j < 4; j++) begin
         chk(done0 == 0 && done1 == 0, "R8 idle bytes no done", 32'(done0), 32'd0);
         chk(dig0 == held, "R8 idle bytes no change", dig0, held);
         @(negedge clk);
      end

      // R5: none mode, expect deliberately wrong
      run_unit(3, 6, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, "none");

      // R6: check mode match and mismatch
      run_unit(3, 10, 1'b0, 1'b1, 1'b1, ref_crc(3, 10, 4), "match");
      run_unit(3, 10, 1'b0, 1'b1, 1'b1, ref_crc(3, 10, 4) ^ 32'h1, "differ");

      // R7: abort during data phase
      digest_en_i = 1'b1; check_en_i = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         start_i = (i == 0); byte_valid_i = 1'b1; byte_i = pat(1, i); last_i = 1'b0;
      end
      run_unit(2, 9, 1'b0, 1'b1, 1'b0, 32'h0, "abort data R7");
      chk(u1_dig == 32'hE3069283, "R7 restart after abort", u1_dig, 32'hE3069283);

      // R7: abort during padding (5 bytes leave 3 pad cycles)
      send(3, 5, 1'b0);
      run_unit(0, 32, 1'b0, 1'b1, 1'b0, 32'h0, "abort pad R7");
      chk(dig0 == 32'h8A9136AA, "R7 restart during padding", dig0, 32'h8A9136AA);

      @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule